// File: doc/BRIEF.md
# Reset Boot Mode Sequencer

This block decides, at the moment reset is released, how the processor core comes up. Four strap inputs are captured while reset is held. From them it picks a memory configuration (full-memory or host-attached), an acknowledge-pin drive style, and one of three boot methods. It then keeps the core stalled until that method has finished.

In the byte-load method the block reads a fixed run of bytes from byte memory. It packs each group of three into a 24-bit program word and writes the words to program memory from address 0 upward. In the host-load method the block writes nothing. It watches the host's write strobes into internal program memory and frees the core as soon as the host writes program address 0. In the direct-start method the core is freed right after reset.

One strap pin also serves as a general-purpose flag once the chip is running. The captured settings therefore ignore every strap change made after reset.

Top module: `boot_mode_seq`

## Requirements
- R1: The straps are captured on every clock edge that sees `rst_n` low. Strap changes after release alter neither the configuration outputs nor the boot method.
- R2: Straps C,B,A = 0,0,0 select the byte-load method with `mem_host_cfg` = 0. Strap D has no effect. A host write does not free the core early.
- R3: Straps C,B,A = 0,1,0 select direct start with `mem_host_cfg` = 0. Strap D has no effect. `core_run` is 1 after the first clock edge that sees `rst_n` high.
- R4: Straps C,B,A = 1,0,0 select the byte-load method with `mem_host_cfg` = 1.
- R5: Straps C,B,A = 1,0,1 select the host-load method with `mem_host_cfg` = 1. `core_run` rises on the edge that samples `host_we` = 1 with `host_addr` = 0. A host write to any other address leaves the core stalled.
- R6: `ack_open_drain` equals strap D while `mem_host_cfg` = 1, and is 0 otherwise. The value 1 means open-drain; 0 means driven at both levels.
- R7: A byte-load fetches 96 bytes from byte addresses 0 to 95, one request per cycle. Read data arrives one cycle after `bm_rd_en`. Word k is {byte 3k, byte 3k+1, byte 3k+2}, most significant byte first, and is written to `pm_addr` = k.
- R8: Every other C,B,A combination behaves as direct start with `mem_host_cfg` = 0 and `ack_open_drain` = 0, and sets `mode_invalid` = 1 until the next reset.
- R9: `core_run` is 0 while `rst_n` is low. In byte-load it stays 0 until the edge that completes the 32nd word write, then rises. It stays 1 until the next reset. A reset in the middle of a load restarts the load from byte 0.
- R10: In direct-start and host-load modes, and during reset, `pm_we` and `bm_rd_en` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; straps are captured while it is low |
| strap_a | input | 1 | Mode strap A |
| strap_b | input | 1 | Mode strap B |
| strap_c | input | 1 | Mode strap C, pin shared with a general-purpose flag |
| strap_d | input | 1 | Mode strap D, acknowledge drive style |
| bm_rd_en | output | 1 | Byte-memory read request |
| bm_addr | output | BM_AW | Byte-memory read address |
| bm_rdata | input | BYTE_W | Byte-memory read data, valid one cycle after the request |
| pm_we | output | 1 | Program-memory write strobe |
| pm_addr | output | PM_AW | Program-memory write address |
| pm_wdata | output | BYTE_W*WORD_BYTES | Program-memory write data |
| host_we | input | 1 | Host write strobe into internal program memory (monitored) |
| host_addr | input | PM_AW | Host write address (monitored) |
| core_run | output | 1 | 1 lets the core execute; 0 stalls it |
| mem_host_cfg | output | 1 | 1 = host memory configuration, 0 = full-memory configuration |
| ack_open_drain | output | 1 | 1 = acknowledge pin open-drain, 0 = actively driven |
| mode_invalid | output | 1 | An unlisted strap combination was captured |

## Verification
A wrong captured mode shows up on the configuration outputs in the first cycle after release. It shows up on `core_run` one edge later, or as byte reads that should not be there. A fault in the byte counter or the packing register shows up on the same edge as the first affected `pm_we`, as a wrong address or a wrong byte order. A fault in the release logic shows up as `core_run` rising too early, during the load or on a host write to a nonzero address. It can also show up as `core_run` never rising at all, which the bench detects after a fixed wait.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;

   typedef enum logic [1:0] {
      BK_NONE = 2'd0,
      BK_BYTE = 2'd1,
      BK_HOST = 2'd2
   } boot_kind_e;

   typedef struct packed {
      boot_kind_e kind;
      logic       host_cfg;
      logic       ack_od;
      logic       invalid;
   } boot_cfg_t;

   // Strap decode: C,B,A select method and memory map, D picks the ack drive style
   function automatic boot_cfg_t decode_straps(input logic d, input logic c,
                                               input logic b, input logic a);
      boot_cfg_t r;
      r = '{kind: BK_NONE, host_cfg: 1'b0, ack_od: 1'b0, invalid: 1'b0};
      case ({c, b, a})
         3'b000: r.kind = BK_BYTE;
         3'b010: r.kind = BK_NONE;
         3'b100: begin
            r.kind     = BK_BYTE;
            r.host_cfg = 1'b1;
         end
         3'b101: begin
            r.kind     = BK_HOST;
            r.host_cfg = 1'b1;
         end
         default: r.invalid = 1'b1;
      endcase
      r.ack_od = r.host_cfg & d;
      return r;
   endfunction

endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch
   import boot_mode_pkg::*;
#(
   parameter bit REG_DECODE = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      strap_a,
   input  logic      strap_b,
   input  logic      strap_c,
   input  logic      strap_d,
   output boot_cfg_t cfg
);

   generate
      if (REG_DECODE) begin : g_dec_reg
         // store the decoded result: decode logic stays off the output path
         boot_cfg_t cfg_q;
         always_ff @(posedge clk) begin
            if (!rst_n) cfg_q <= decode_straps(strap_d, strap_c, strap_b, strap_a);
         end
         assign cfg = cfg_q;
      end else begin : g_raw_reg
         // store only four raw bits and decode behind the flops
         logic [3:0] raw_q;
         always_ff @(posedge clk) begin
            if (!rst_n) raw_q <= {strap_d, strap_c, strap_b, strap_a};
         end
         assign cfg = decode_straps(raw_q[3], raw_q[2], raw_q[1], raw_q[0]);
      end
   endgenerate

endmodule

// File: rtl/boot_byte_loader.sv
module boot_byte_loader #(
   parameter int BYTE_W     = 8,
   parameter int WORD_BYTES = 3,
   parameter int BOOT_WORDS = 32,
   parameter int BM_AW      = 14,
   parameter int PM_AW      = 14,
   parameter int BM_BASE    = 0,
   parameter int PM_BASE    = 0,
   parameter bit MSB_FIRST  = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         en,
   output logic                         bm_rd_en,
   output logic [BM_AW-1:0]             bm_addr,
   input  logic [BYTE_W-1:0]            bm_rdata,
   output logic                         pm_we,
   output logic [PM_AW-1:0]             pm_addr,
   output logic [BYTE_W*WORD_BYTES-1:0] pm_wdata,
   output logic                         last_wr
);

   localparam int WORD_W      = BYTE_W * WORD_BYTES;
   localparam int TOTAL_BYTES = WORD_BYTES * BOOT_WORDS;
   localparam int ICNT_W      = $clog2(TOTAL_BYTES + 1);
   localparam int POS_W       = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
   localparam int WCNT_W      = (BOOT_WORDS > 1) ? $clog2(BOOT_WORDS) : 1;
   localparam int LAST_POS    = WORD_BYTES - 1;
   localparam int LAST_WORD   = BOOT_WORDS - 1;
   localparam int ASM_W       = (WORD_BYTES > 1) ? (WORD_BYTES - 1) * BYTE_W : BYTE_W;

   logic [ICNT_W-1:0] issue_cnt_q;
   logic              issue;
   logic              rd_vld_q;
   logic [POS_W-1:0]  pos_q;
   logic [WCNT_W-1:0] word_q;
   logic              word_end;

   // one byte request per cycle until the whole image has been requested
   assign issue    = en && (issue_cnt_q != ICNT_W'(TOTAL_BYTES));
   assign word_end = (pos_q == POS_W'(LAST_POS));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issue_cnt_q <= '0;
         rd_vld_q    <= 1'b0;
         pos_q       <= '0;
         word_q      <= '0;
      end else begin
         rd_vld_q <= issue;
         if (issue) issue_cnt_q <= issue_cnt_q + 1'b1;
         if (rd_vld_q) begin
            if (word_end) begin
               pos_q  <= '0;
               word_q <= word_q + 1'b1;
            end else begin
               pos_q <= pos_q + 1'b1;
            end
         end
      end
   end

   assign bm_rd_en = issue;
   assign bm_addr  = BM_AW'(BM_BASE) + BM_AW'(issue_cnt_q);
   assign pm_we    = rd_vld_q && word_end;
   assign pm_addr  = PM_AW'(PM_BASE) + PM_AW'(word_q);
   assign last_wr  = pm_we && (word_q == WCNT_W'(LAST_WORD));

   generate
      if (WORD_BYTES == 1) begin : g_single
         assign pm_wdata = bm_rdata;
      end else if (MSB_FIRST) begin : g_msb
         logic [ASM_W-1:0] asm_q;
         always_ff @(posedge clk) begin
            if (!rst_n) asm_q <= '0;
            else if (rd_vld_q && !word_end) asm_q <= ASM_W'({asm_q, bm_rdata});
         end
         assign pm_wdata = {asm_q, bm_rdata};
      end else begin : g_lsb
         logic [ASM_W-1:0] asm_q;
         always_ff @(posedge clk) begin
            if (!rst_n) asm_q <= '0;
            else if (rd_vld_q && !word_end) asm_q <= ASM_W'({bm_rdata, asm_q} >> BYTE_W);
         end
         assign pm_wdata = {bm_rdata, asm_q};
      end
   endgenerate

   // unused in the default build; keeps WORD_W tied to the port width
   generate
      if (WORD_W != BYTE_W * WORD_BYTES) begin : g_bad_w
         $error("boot_byte_loader: word width mismatch");
      end
   endgenerate

endmodule

// File: rtl/boot_host_watch.sv
module boot_host_watch #(
   parameter int PM_AW        = 14,
   parameter int RELEASE_ADDR = 0
) (
   input  logic             en,
   input  logic             host_we,
   input  logic [PM_AW-1:0] host_addr,
   output logic             release_o
);

   assign release_o = en && host_we && (host_addr == PM_AW'(RELEASE_ADDR));

endmodule

// File: rtl/boot_mode_seq.sv
module boot_mode_seq
   import boot_mode_pkg::*;
#(
   parameter int BYTE_W            = 8,
   parameter int WORD_BYTES        = 3,
   parameter int BOOT_WORDS        = 32,
   parameter int BM_AW             = 14,
   parameter int PM_AW             = 14,
   parameter int BM_BASE           = 0,
   parameter int PM_BASE           = 0,
   parameter int HOST_RELEASE_ADDR = 0,
   parameter bit MSB_FIRST         = 1'b1,
   parameter bit REG_DECODE        = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         strap_a,
   input  logic                         strap_b,
   input  logic                         strap_c,
   input  logic                         strap_d,
   output logic                         bm_rd_en,
   output logic [BM_AW-1:0]             bm_addr,
   input  logic [BYTE_W-1:0]            bm_rdata,
   output logic                         pm_we,
   output logic [PM_AW-1:0]             pm_addr,
   output logic [BYTE_W*WORD_BYTES-1:0] pm_wdata,
   input  logic                         host_we,
   input  logic [PM_AW-1:0]             host_addr,
   output logic                         core_run,
   output logic                         mem_host_cfg,
   output logic                         ack_open_drain,
   output logic                         mode_invalid
);

   localparam int TOTAL_BYTES = WORD_BYTES * BOOT_WORDS;

   generate
      if (BYTE_W < 1 || WORD_BYTES < 1 || BOOT_WORDS < 1) begin : g_bad_size
         $error("boot_mode_seq: byte width, word size and word count must be positive");
      end
      if (BM_BASE + TOTAL_BYTES > (1 << BM_AW)) begin : g_bad_bm
         $error("boot_mode_seq: boot image does not fit the byte address space");
      end
      if (PM_BASE + BOOT_WORDS > (1 << PM_AW)) begin : g_bad_pm
         $error("boot_mode_seq: boot words do not fit the program address space");
      end
      if (HOST_RELEASE_ADDR >= (1 << PM_AW)) begin : g_bad_rel
         $error("boot_mode_seq: host release address out of range");
      end
   endgenerate

   boot_cfg_t  cfg;
   logic [1:0] boot_kind;
   logic       byte_en;
   logic       host_en;
   logic       byte_done;
   logic       host_done;
   logic       release_now;
   logic       run_q;

   boot_strap_latch #(
      .REG_DECODE (REG_DECODE)
   ) strap_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .strap_a (strap_a),
      .strap_b (strap_b),
      .strap_c (strap_c),
      .strap_d (strap_d),
      .cfg     (cfg)
   );

   assign boot_kind = cfg.kind;
   assign byte_en   = rst_n && (cfg.kind == BK_BYTE);
   assign host_en   = rst_n && (cfg.kind == BK_HOST);

   boot_byte_loader #(
      .BYTE_W     (BYTE_W),
      .WORD_BYTES (WORD_BYTES),
      .BOOT_WORDS (BOOT_WORDS),
      .BM_AW      (BM_AW),
      .PM_AW      (PM_AW),
      .BM_BASE    (BM_BASE),
      .PM_BASE    (PM_BASE),
      .MSB_FIRST  (MSB_FIRST)
   ) loader_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (byte_en),
      .bm_rd_en (bm_rd_en),
      .bm_addr  (bm_addr),
      .bm_rdata (bm_rdata),
      .pm_we    (pm_we),
      .pm_addr  (pm_addr),
      .pm_wdata (pm_wdata),
      .last_wr  (byte_done)
   );

   boot_host_watch #(
      .PM_AW        (PM_AW),
      .RELEASE_ADDR (HOST_RELEASE_ADDR)
   ) host_i (
      .en        (host_en),
      .host_we   (host_we),
      .host_addr (host_addr),
      .release_o (host_done)
   );

   always_comb begin
      case (cfg.kind)
         BK_BYTE: release_now = byte_done;
         BK_HOST: release_now = host_done;
         default: release_now = 1'b1;
      endcase
   end

   // run flag: cleared by reset, set once by the release condition
   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= 1'b0;
      else if (release_now) run_q <= 1'b1;
   end

   assign core_run       = run_q;
   assign mem_host_cfg   = cfg.host_cfg;
   assign ack_open_drain = cfg.ack_od;
   assign mode_invalid   = cfg.invalid;

endmodule

// File: rtl/boot_mode_seq_chk.sv
module boot_mode_seq_chk
   import boot_mode_pkg::*;
#(
   parameter int PM_AW             = 14,
   parameter int BOOT_WORDS        = 32,
   parameter int PM_BASE           = 0,
   parameter int HOST_RELEASE_ADDR = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       boot_kind,
   input logic             core_run,
   input logic             pm_we,
   input logic [PM_AW-1:0] pm_addr,
   input logic             bm_rd_en,
   input logic             host_we,
   input logic [PM_AW-1:0] host_addr,
   input logic             mem_host_cfg,
   input logic             ack_open_drain,
   input logic             mode_invalid
);

   logic host_hit;
   assign host_hit = host_we && (host_addr == PM_AW'(HOST_RELEASE_ADDR));

   assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable({boot_kind, mem_host_cfg, ack_open_drain, mode_invalid}));

   assert_noboot_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_kind == BK_NONE && $past(rst_n)) |-> core_run);

   assert_host_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_kind == BK_HOST && host_hit) |=> core_run);

   assert_host_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_kind == BK_HOST && !core_run && !host_hit) |=> !core_run);

   assert_ack_host_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_open_drain |-> mem_host_cfg);

   assert_write_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pm_we |-> (int'(pm_addr) >= PM_BASE && int'(pm_addr) < PM_BASE + BOOT_WORDS));

   assert_invalid_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mode_invalid |-> (!mem_host_cfg && boot_kind == BK_NONE));

   assert_run_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      core_run |=> core_run);

   assert_write_before_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pm_we |-> !core_run);

   assert_no_stray_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_we || bm_rd_en) |-> (boot_kind == BK_BYTE));

endmodule

bind boot_mode_seq boot_mode_seq_chk #(
   .PM_AW             (PM_AW),
   .BOOT_WORDS        (BOOT_WORDS),
   .PM_BASE           (PM_BASE),
   .HOST_RELEASE_ADDR (HOST_RELEASE_ADDR)
) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .boot_kind      (boot_kind),
   .core_run       (core_run),
   .pm_we          (pm_we),
   .pm_addr        (pm_addr),
   .bm_rd_en       (bm_rd_en),
   .host_we        (host_we),
   .host_addr      (host_addr),
   .mem_host_cfg   (mem_host_cfg),
   .ack_open_drain (ack_open_drain),
   .mode_invalid   (mode_invalid)
);

// File: tb/boot_mode_seq_tb_top.sv
module boot_mode_seq_tb_top;

   localparam int BYTE_W     = 8;
   localparam int WORD_BYTES = 3;
   localparam int BOOT_WORDS = 32;
   localparam int BM_AW      = 14;
   localparam int PM_AW      = 14;
   localparam int WORD_W     = BYTE_W * WORD_BYTES;
   localparam int NBYTES     = WORD_BYTES * BOOT_WORDS;

   // {straps D,C,B,A} , {invalid, kind(0 none/1 byte/2 host), host_cfg, ack_od}
   localparam logic [8:0] VEC [16] = '{
      {4'd0,  5'b0_01_0_0},
      {4'd1,  5'b1_00_0_0},
      {4'd2,  5'b0_00_0_0},
      {4'd3,  5'b1_00_0_0},
      {4'd4,  5'b0_01_1_0},
      {4'd5,  5'b0_10_1_0},
      {4'd6,  5'b1_00_0_0},
      {4'd7,  5'b1_00_0_0},
      {4'd8,  5'b0_01_0_0},
      {4'd9,  5'b1_00_0_0},
      {4'd10, 5'b0_00_0_0},
      {4'd11, 5'b1_00_0_0},
      {4'd12, 5'b0_01_1_1},
      {4'd13, 5'b0_10_1_1},
      {4'd14, 5'b1_00_0_0},
      {4'd15, 5'b1_00_0_0}
   };

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0;
   logic strap_a = 1'b0, strap_b = 1'b0, strap_c = 1'b0, strap_d = 1'b0;
   logic host_we = 1'b0;
   logic [PM_AW-1:0] host_addr = '0;
   logic [BYTE_W-1:0] bm_rdata = '0;
   logic bm_rd_en, pm_we, core_run, mem_host_cfg, ack_open_drain, mode_invalid;
   logic [BM_AW-1:0] bm_addr;
   logic [PM_AW-1:0] pm_addr;
   logic [WORD_W-1:0] pm_wdata;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [BYTE_W-1:0] bmem [0:255];

   boot_mode_seq dut_i (
      .clk(clk), .rst_n(rst_n),
      .strap_a(strap_a), .strap_b(strap_b), .strap_c(strap_c), .strap_d(strap_d),
      .bm_rd_en(bm_rd_en), .bm_addr(bm_addr), .bm_rdata(bm_rdata),
      .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
      .host_we(host_we), .host_addr(host_addr),
      .core_run(core_run), .mem_host_cfg(mem_host_cfg),
      .ack_open_drain(ack_open_drain), .mode_invalid(mode_invalid)
   );

   // byte memory model: one-cycle read latency
   always @(posedge clk) if (bm_rd_en) bm_rdata <= bmem[bm_addr[7:0]];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [WORD_W-1:0] exp_word(input int k);
      logic [WORD_W-1:0] w = '0;
      for (int j = 0; j < WORD_BYTES; j++) w = (w << BYTE_W) | WORD_W'(bmem[k * WORD_BYTES + j]);
      return w;
   endfunction

   task automatic put_straps(input logic [3:0] s);
      {strap_d, strap_c, strap_b, strap_a} = s;
   endtask

   task automatic hold_reset(input logic [3:0] s);
      @(negedge clk);
      rst_n = 1'b0;
      host_we = 1'b0;
      put_straps(~s);
      @(negedge clk);
      put_straps(s);                      // R1: last captured value wins
      repeat (2) @(negedge clk);
      chk("R9 core_run low in reset", {31'd0, core_run}, 32'd0);
      chk("R10 no access in reset", {30'd0, pm_we, bm_rd_en}, 32'd0);
   endtask

   task automatic run_vec(input logic [8:0] v);
      logic [3:0] s = v[8:5];
      logic inv = v[4];
      logic [1:0] k = v[3:2];
      logic h = v[1];
      logic o = v[0];
      int nw = 0;
      string tag;
      tag = inv ? "R8" : (k == 2'd1 ? (h ? "R4" : "R2") : (k == 2'd2 ? "R5" : "R3"));
      hold_reset(s);
      rst_n = 1'b1;
      @(negedge clk);
      put_straps(~s);                     // R1: flag use of the pins after release
      if (k == 2'd0) chk({tag, " R3 core_run after first edge"}, {31'd0, core_run}, 32'd1);
      else chk("R9 core_run held while booting", {31'd0, core_run}, 32'd0);
      for (int cyc = 0; cyc < NBYTES + 20; cyc++) begin
         if (pm_we) begin
            if (k != 2'd1) chk("R10 stray program write", 32'd1, 32'd0);
            else begin
               chk("R7 program address", 32'(pm_addr), 32'(nw));
               chk("R7 program word", 32'(pm_wdata), 32'(exp_word(nw)));
               chk("R9 core_run low during load", {31'd0, core_run}, 32'd0);
            end
            nw++;
         end
         if (bm_rd_en && k != 2'd1) chk("R10 stray byte read", 32'd1, 32'd0);
         @(negedge clk);
      end
      chk({tag, " R1 memory configuration"}, {31'd0, mem_host_cfg}, {31'd0, h});
      chk("R6 acknowledge drive style", {31'd0, ack_open_drain}, {31'd0, o});
      chk("R8 invalid flag", {31'd0, mode_invalid}, {31'd0, inv});
      if (k == 2'd1) begin
         chk({tag, " word count"}, 32'(nw), 32'(BOOT_WORDS));
         chk("R9 core_run after last word", {31'd0, core_run}, 32'd1);
      end else begin
         chk("R10 no words written", 32'(nw), 32'd0);
      end
      if (k == 2'd2) begin
         chk("R5 held before host write", {31'd0, core_run}, 32'd0);
         host_we = 1'b1;
         host_addr = PM_AW'(7);
         @(negedge clk);
         host_we = 1'b0;
         @(negedge clk);
         chk("R5 nonzero host address keeps stall", {31'd0, core_run}, 32'd0);
         host_we = 1'b1;
         host_addr = '0;
         @(negedge clk);
         host_we = 1'b0;
         chk("R5 host write to address 0 releases", {31'd0, core_run}, 32'd1);
      end
      put_straps(s ^ 4'b0101);
      repeat (4) @(negedge clk);
      chk("R9 core_run stays high", {31'd0, core_run}, 32'd1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) bmem[i] = 8'((i * 73 + 19) ^ (i >> 2));

      // table walk over every strap combination
      for (int i = 0; i < 16; i++) run_vec(VEC[i]);

      // R9: reset in the middle of a byte load, then a clean reload
      hold_reset(4'd0);
      rst_n = 1'b1;
      repeat (40) @(negedge clk);
      chk("R9 core_run low mid-load", {31'd0, core_run}, 32'd0);
      run_vec(VEC[4]);

      // R2: host write to address 0 must not cut a byte load short
      hold_reset(4'd8);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      host_we = 1'b1;
      host_addr = '0;
      @(negedge clk);
      host_we = 1'b0;
      chk("R2 host write ignored in byte load", {31'd0, core_run}, 32'd0);
      repeat (NBYTES + 10) @(negedge clk);
      chk("R2 byte load completes", {31'd0, core_run}, 32'd1);

      // R1: straps toggling every cycle after release leave direct start intact
      hold_reset(4'd2);
      rst_n = 1'b1;
      for (int c = 0; c < 8; c++) begin
         @(negedge clk);
         put_straps(4'(c * 5));
      end
      chk("R1 config unchanged by strap toggling", {29'd0, mem_host_cfg, ack_open_drain, mode_invalid}, 32'd0);
      chk("R3 direct start still running", {31'd0, core_run}, 32'd1);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule